// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

The sequencer owns the reset of a processor. It takes three reset sources and turns them into one internal reset for the core, memory and peripherals, plus a reset for the clock-multiplier PLL. The three sources are an active-low board pin, a write-one-to-set request bit in a small system control register, and a bidirectional reset-out pad sensed as an input. Each source sets its own reset-out direction and its own pulse length, and each has its own rule for the PLL. A hardware reset holds the PLL in reset and then waits out the PLL lock interval in input-clock cycles. A software reset leaves the PLL running and drives reset-out for a fixed number of peripheral-clock periods. A running reset leaves both the PLL and the reset-out driver alone and follows the level sensed on the pad.

The whole block runs on the input clock. Peripheral-clock periods arrive as a one-cycle strobe, `pclk_tick`. The board pin is the only asynchronous reset, and it wins over everything. The pin passes through a synchronizer that asserts at once and releases after two clock edges. The synchronizer output resets every flop, so a pin assertion aborts any sequence in progress.

The controller has five states:
- `ST_HW_HOLD`: the pin is asserted, or its release is still in the synchronizer. PLL reset is asserted.
- `ST_HW_LOCK`: counts the lock interval.
- `ST_RUN`: normal operation.
- `ST_SW_PULSE`: counts peripheral ticks for a software reset.
- `ST_RUN_RST`: follows the sensed pad.

The transitions are:
- HOLD→LOCK: on the first edge after reset release.
- LOCK→RUN: when the lock count expires.
- RUN→RUN_RST: when the sensed pad is low and the sense is not blanked.
- RUN→SW_PULSE: when the request bit is set.
- SW_PULSE→RUN: on the last tick.
- RUN_RST→RUN: when the sensed pad returns high.
- Any state→HOLD: asynchronously, on the pin.

Top module: `rst_sequencer`

## Requirements
- R1: `pll_rst` rises in the same time step that `rst_pin_n` falls. It stays high while the pin is low. After the pin is released at a falling clock edge, it is still high after two rising edges and low after the third.
- R2: After `pll_rst` falls, `core_rst_n` stays low for exactly `LOCK_CYCLES` clock cycles (default 4096) and then rises. The lock count restarts from zero on every hardware reset.
- R3: From pin assertion until `core_rst_n` rises after a hardware reset, `rstout_oe` is 1 and `rstout_n_o` is 0. In normal operation `rstout_oe` is 0.
- R4: A write with `ctl_wr`=1 and `ctl_wdata` bit 0 = 1 requests a software reset. `core_rst_n` is still high one edge after the write edge and low after the second.
- R5: A software reset holds `core_rst_n` low, with `rstout_oe`=1 and `rstout_n_o`=0. It ends on the rising edge that samples the `SW_TICKS`-th (default 2) high `pclk_tick` of the pulse.
- R6: Neither a software reset nor a running reset ever raises `pll_rst`.
- R7: `ctl_rdata` returns the written value of bits 7..1. Bit 0 reads 1 while a software request is pending or running, and it clears itself on the edge that ends the software pulse.
- R8: In normal operation, `rstout_i` low makes `core_rst_n` go low three edges later. The reset lasts as many cycles as the input was low, and `rstout_oe` stays 0 throughout.
- R9: After the block stops driving reset-out, the sensed pad is ignored for `SYNC_STAGES` edges, so that the echo of its own drive does not start a running reset.
- R10: Asserting `rst_pin_n` during a software or running reset aborts it at once: PLL reset, cause code 1 and a cleared control register. A full lock interval follows the release.
- R11: `rst_cause` reads 1 after a hardware reset, 2 after a software reset and 3 after a running reset. It is updated on the edge that enters the reset.
- R12: A software request written during a running reset stays pending and starts its pulse one edge after the block returns to normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counting of the lock interval uses it |
| rst_pin_n | input | 1 | Active-low external reset pin, asynchronous |
| pclk_tick | input | 1 | One-cycle strobe per peripheral-clock period |
| ctl_wr | input | 1 | Write strobe for the system control register |
| ctl_wdata | input | CTL_W | Write data; bit 0 requests a software reset |
| ctl_rdata | output | CTL_W | System control register contents |
| rstout_i | input | 1 | Level sensed on the reset-out pad, active low |
| rstout_n_o | output | 1 | Value driven on the reset-out pad, active low |
| rstout_oe | output | 1 | Output enable of the reset-out pad driver |
| core_rst_n | output | 1 | Core, memory and peripheral reset, active low |
| pll_rst | output | 1 | PLL reset, active high |
| rst_cause | output | 2 | Source of the most recent reset: 1 hardware, 2 software, 3 running |

## Verification
The hardest behaviour to reach is the echo that follows a driven pulse. The pad still reads low for two edges after the driver turns off, and only the sense blanking keeps that from starting a running reset. To reach it, the bench wires the pad as a real tri-state net, so `rstout_i` carries the block's own drive whenever `rstout_oe` is high. It then checks that no reset follows any software pulse. The software pulse is swept over every tick period from 1 to 4 and every tick phase, and the bench checks that each pulse spans exactly two ticks. Aborts are forced by asserting the pin in the middle of a software pulse and in the middle of a running reset.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_HW_HOLD  = 3'd0,
        ST_HW_LOCK  = 3'd1,
        ST_RUN      = 3'd2,
        ST_SW_PULSE = 3'd3,
        ST_RUN_RST  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_HW  = 2'd1,
        CAUSE_SW  = 2'd2,
        CAUSE_RUN = 2'd3
    } rst_cause_e;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2); // R1
    end
endmodule

// File: rtl/rst_seq_ctl.sv
module rst_seq_ctl #(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             sw_clr,
    output logic [CTL_W-1:0] rdata,
    output logic             sw_req
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (wr && wdata[0]) begin
            req_q <= 1'b1;
        end else if (sw_clr) begin
            req_q <= 1'b0;
        end
    end

    generate
        if (CTL_W > 1) begin : g_upper
            logic [CTL_W-1:1] upper_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    upper_q <= '0;
                end else if (wr) begin
                    upper_q <= wdata[CTL_W-1:1];
                end
            end
            assign rdata = {upper_q, req_q};
        end else begin : g_bit_only
            assign rdata = req_q;
        end
    endgenerate

    assign sw_req = req_q;

    AST_CLR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |-> req_q); // R7
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 4096,
    parameter int SW_TICKS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pclk_tick,
    input  logic       sense_n,
    input  logic       sw_req,
    output logic       sw_clr,
    output logic       core_rst_n,
    output logic       pll_rst,
    output logic       drive_en,
    output logic [1:0] cause
);
    localparam int CNT_LIM = (LOCK_CYCLES > SW_TICKS) ? LOCK_CYCLES : SW_TICKS;
    localparam int CNT_W   = $clog2(CNT_LIM + 1);
    localparam int BLK_W   = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);
    localparam logic [CNT_W-1:0] SW_LAST   = CNT_W'(SW_TICKS - 1);
    localparam logic [BLK_W-1:0] BLK_INIT  = BLK_W'(SYNC_STAGES);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [BLK_W-1:0] blank_q, blank_d;
    rst_cause_e       cause_q, cause_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HW_HOLD;
            cnt_q   <= '0;
            blank_q <= '0;
            cause_q <= CAUSE_HW;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            blank_q <= blank_d;
            cause_q <= cause_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        blank_d = blank_q;
        cause_d = cause_q;
        sw_clr  = 1'b0;
        unique case (state_q)
            ST_HW_HOLD: begin
                state_d = ST_HW_LOCK;
                cnt_d   = '0;
            end
            ST_HW_LOCK: begin
                if (cnt_q == LOCK_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                    blank_d = BLK_INIT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (blank_q != '0) begin
                    blank_d = blank_q - 1'b1;
                end
                if (blank_q == '0 && !sense_n) begin
                    state_d = ST_RUN_RST;
                    cause_d = CAUSE_RUN;
                end else if (sw_req) begin
                    state_d = ST_SW_PULSE;
                    cnt_d   = '0;
                    cause_d = CAUSE_SW;
                end
            end
            ST_SW_PULSE: begin
                if (pclk_tick) begin
                    if (cnt_q == SW_LAST) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                        blank_d = BLK_INIT;
                        sw_clr  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_RUN_RST: begin
                if (sense_n) begin
                    state_d = ST_RUN;
                end
            end
            default: begin
                state_d = ST_HW_HOLD;
            end
        endcase
    end

    // outputs
    always_comb begin
        core_rst_n = 1'b0;
        pll_rst    = 1'b0;
        drive_en   = 1'b0;
        unique case (state_q)
            ST_HW_HOLD: begin
                pll_rst  = 1'b1;
                drive_en = 1'b1;
            end
            ST_HW_LOCK:  drive_en   = 1'b1;
            ST_RUN:      core_rst_n = 1'b1;
            ST_SW_PULSE: drive_en   = 1'b1;
            ST_RUN_RST:  drive_en   = 1'b0;
            default:     pll_rst    = 1'b1;
        endcase
    end

    assign cause = cause_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(CNT_LIM)); // R2
    AST_LOCK_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HW_LOCK && $past(state_q) != ST_HW_LOCK) |-> ($past(state_q) == ST_HW_HOLD && cnt_q == '0)); // R2
    AST_SW_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SW_PULSE && state_q == ST_RUN) |-> $past(pclk_tick)); // R5
    AST_SENSE_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_RST && $past(state_q) != ST_RUN_RST) |-> ($past(state_q) == ST_RUN && $past(blank_q) == '0)); // R9
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 4096,
    parameter int SW_TICKS    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CTL_W       = 8
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             pclk_tick,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             rstout_i,
    output logic             rstout_n_o,
    output logic             rstout_oe,
    output logic             core_rst_n,
    output logic             pll_rst,
    output logic [1:0]       rst_cause
);
    logic rst_sys_n;
    logic sense_n;
    logic sw_req;
    logic sw_clr;
    logic drive_en;

    rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pin_sync (
        .clk    (clk),
        .arst_n (rst_pin_n),
        .d      (1'b1),
        .q      (rst_sys_n)
    );

    rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sense_sync (
        .clk    (clk),
        .arst_n (rst_sys_n),
        .d      (rstout_i),
        .q      (sense_n)
    );

    rst_seq_ctl #(.CTL_W(CTL_W)) i_ctl (
        .clk    (clk),
        .rst_n  (rst_sys_n),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .sw_clr (sw_clr),
        .rdata  (ctl_rdata),
        .sw_req (sw_req)
    );

    rst_seq_fsm #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .SW_TICKS    (SW_TICKS),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_sys_n),
        .pclk_tick  (pclk_tick),
        .sense_n    (sense_n),
        .sw_req     (sw_req),
        .sw_clr     (sw_clr),
        .core_rst_n (core_rst_n),
        .pll_rst    (pll_rst),
        .drive_en   (drive_en),
        .cause      (rst_cause)
    );

    assign rstout_oe  = drive_en;
    assign rstout_n_o = !drive_en;

    AST_PLL_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_sys_n)
        !pll_rst |=> !pll_rst); // R6
    AST_SW_BIT_SELFCLR: assert property (@(posedge clk) disable iff (!rst_sys_n)
        ($rose(core_rst_n) && rst_cause == CAUSE_SW && !$past(ctl_wr)) |-> !ctl_rdata[0]); // R7
    AST_RUNRST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sys_n)
        (rst_cause == CAUSE_RUN && !core_rst_n) |-> !rstout_oe); // R8
    AST_SW_DRIVES_PAD: assert property (@(posedge clk) disable iff (!rst_sys_n)
        (rst_cause == CAUSE_SW && !core_rst_n) |-> (rstout_oe && !rstout_n_o)); // R5
endmodule

// File: tb/test_rst_sequencer.sv
`timescale 1ns/1ps
module test_rst_sequencer;
    localparam int LOCK = 4096;

    logic       clk = 1'b0;
    logic       rst_pin_n;
    logic       pclk_tick;
    logic       ctl_wr;
    logic [7:0] ctl_wdata;
    logic [7:0] ctl_rdata;
    logic       rstout_n_o, rstout_oe, core_rst_n, pll_rst;
    logic [1:0] rst_cause;
    logic       ext_n;
    logic       pad;

    int n_tests = 0;
    int n_fail  = 0;
    int per = 1;
    int ph  = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign pad = rstout_oe ? rstout_n_o : ext_n;

    rst_sequencer #(.LOCK_CYCLES(LOCK), .SW_TICKS(2), .SYNC_STAGES(2), .CTL_W(8)) i_rst_sequencer (
        .clk        (clk),
        .rst_pin_n  (rst_pin_n),
        .pclk_tick  (pclk_tick),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .rstout_i   (pad),
        .rstout_n_o (rstout_n_o),
        .rstout_oe  (rstout_oe),
        .core_rst_n (core_rst_n),
        .pll_rst    (pll_rst),
        .rst_cause  (rst_cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ph = (ph + 1) % per;
        pclk_tick = (ph == 0);
    endtask

    task automatic hw_release(input string req);
        int n;
        int bad;
        rst_pin_n = 1'b1;
        step();
        chk(pll_rst == 1'b1, "R1 pll held edge1", int'(pll_rst), 1);
        step();
        chk(pll_rst == 1'b1, "R1 pll held edge2", int'(pll_rst), 1);
        step();
        chk(pll_rst == 1'b0, "R1 pll released edge3", int'(pll_rst), 0);
        n = 0;
        bad = 0;
        while (core_rst_n == 1'b0 && n < LOCK + 10) begin
            n++;
            if (!(rstout_oe == 1'b1 && rstout_n_o == 1'b0 && pll_rst == 1'b0)) bad++;
            step();
        end
        chk(n == LOCK, req, n, LOCK);
        chk(bad == 0, "R3 reset-out driven during lock", bad, 0);
        chk(rstout_oe == 1'b0, "R3 driver off in run", int'(rstout_oe), 0);
        chk(rst_cause == 2'd1, "R11 cause hardware", int'(rst_cause), 1);
    endtask

    task automatic sw_reset(input int p, input int ph0, input logic [7:0] wval);
        int n;
        int ticks;
        int bad;
        int echo;
        per = p;
        ph = ph0;
        pclk_tick = (ph0 == 0);
        ctl_wr = 1'b1;
        ctl_wdata = wval | 8'h01;
        step();
        ctl_wr = 1'b0;
        chk(core_rst_n == 1'b1, "R4 no reset one edge after write", int'(core_rst_n), 1);
        chk(ctl_rdata[0] == 1'b1, "R7 request bit pending", int'(ctl_rdata[0]), 1);
        step();
        chk(core_rst_n == 1'b0, "R4 reset two edges after write", int'(core_rst_n), 0);
        chk(rst_cause == 2'd2, "R11 cause software", int'(rst_cause), 2);
        n = 0;
        ticks = 0;
        bad = 0;
        while (core_rst_n == 1'b0 && n < 40) begin
            n++;
            if (pclk_tick) ticks++;
            if (!(rstout_oe == 1'b1 && rstout_n_o == 1'b0)) bad++;
            if (pll_rst != 1'b0) bad += 100;
            step();
        end
        chk(ticks == 2, "R5 pulse spans two ticks", ticks, 2);
        chk(n >= 2 && n <= 2 * p, "R5 pulse length bound", n, 2 * p);
        chk(bad == 0, "R6 pad driven and PLL untouched", bad, 0);
        chk(ctl_rdata == (wval & 8'hFE), "R7 self-clear keeps upper bits", int'(ctl_rdata), int'(wval & 8'hFE));
        echo = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (core_rst_n == 1'b0) echo++;
        end
        chk(echo == 0, "R9 no reset from own echo", echo, 0);
    endtask

    task automatic run_reset(input int len);
        int n;
        int first;
        int bad;
        n = 0;
        first = -1;
        bad = 0;
        ext_n = 1'b0;
        for (int i = 1; i <= len + 8; i++) begin
            if (i > len) ext_n = 1'b1;
            step();
            if (core_rst_n == 1'b0) begin
                n++;
                if (first < 0) first = i;
                if (rstout_oe != 1'b0 || pll_rst != 1'b0) bad++;
            end
        end
        ext_n = 1'b1;
        chk(n == len, "R8 running reset length", n, len);
        chk(first == 3, "R8 running reset latency", first, 3);
        chk(bad == 0, "R6 no drive or PLL in running reset", bad, 0);
        chk(rst_cause == 2'd3, "R11 cause running", int'(rst_cause), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_pin_n = 1'b0;
        ext_n = 1'b1;
        ctl_wr = 1'b0;
        ctl_wdata = '0;
        pclk_tick = 1'b1;
        repeat (3) @(negedge clk);
        chk(pll_rst == 1'b1, "R1 pll in reset", int'(pll_rst), 1);
        chk(core_rst_n == 1'b0, "R2 core in reset", int'(core_rst_n), 0);
        chk(rstout_oe == 1'b1 && rstout_n_o == 1'b0, "R3 pad driven in hold", int'(rstout_oe), 1);
        chk(rst_cause == 2'd1, "R11 reset cause", int'(rst_cause), 1);
        chk(ctl_rdata == 8'h00, "R7 register reset", int'(ctl_rdata), 0);
        hw_release("R2 lock interval");

        // software reset sweep over tick period and phase
        for (int p = 1; p <= 4; p++) begin
            for (int q = 0; q < p; q++) begin
                sw_reset(p, q, 8'((p << 5) | (q << 2) | 2));
            end
        end

        // running reset sweep over input low length
        for (int l = 1; l <= 6; l++) begin
            run_reset(l);
            repeat (2) step();
        end

        // R12: software request during running reset waits
        per = 3;
        ph = 0;
        pclk_tick = 1'b1;
        ext_n = 1'b0;
        repeat (4) step();
        ctl_wr = 1'b1;
        ctl_wdata = 8'h41;
        step();
        ctl_wr = 1'b0;
        chk(core_rst_n == 1'b0 && rst_cause == 2'd3, "R12 still running reset", int'(rst_cause), 3);
        chk(ctl_rdata[0] == 1'b1, "R12 request pending", int'(ctl_rdata[0]), 1);
        ext_n = 1'b1;
        repeat (3) step();
        chk(core_rst_n == 1'b1, "R12 back to run", int'(core_rst_n), 1);
        step();
        chk(core_rst_n == 1'b0 && rst_cause == 2'd2, "R12 pending software reset starts", int'(rst_cause), 2);
        for (int i = 0; i < 40 && core_rst_n == 1'b0; i++) step();
        chk(ctl_rdata == 8'h40, "R12 request consumed", int'(ctl_rdata), 8'h40);
        repeat (4) step();

        // R10: pin aborts a software pulse
        per = 4;
        ph = 1;
        pclk_tick = 1'b0;
        ctl_wr = 1'b1;
        ctl_wdata = 8'h81;
        step();
        ctl_wr = 1'b0;
        step();
        chk(core_rst_n == 1'b0 && rst_cause == 2'd2, "R10 software pulse started", int'(rst_cause), 2);
        rst_pin_n = 1'b0;
        #1;
        chk(pll_rst == 1'b1, "R10 abort raises PLL reset", int'(pll_rst), 1);
        chk(rst_cause == 2'd1, "R10 abort cause", int'(rst_cause), 1);
        chk(ctl_rdata == 8'h00, "R10 abort clears register", int'(ctl_rdata), 0);
        step();
        step();
        hw_release("R10 lock after sw abort");
        repeat (3) step();

        // R10: pin aborts a running reset
        ext_n = 1'b0;
        repeat (4) step();
        chk(rst_cause == 2'd3 && core_rst_n == 1'b0, "R10 running reset active", int'(rst_cause), 3);
        rst_pin_n = 1'b0;
        #1;
        chk(pll_rst == 1'b1 && rst_cause == 2'd1, "R10 abort of running reset", int'(pll_rst), 1);
        ext_n = 1'b1;
        step();
        step();
        hw_release("R10 lock after running abort");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule